// File: doc/BRIEF.md
# Divide-by-Three Clock Generator with Half Duty Cycle

This block takes a free-running input clock and produces an output clock whose period is three input periods, high for one and a half input periods and low for the other one and a half. It holds two three-bit one-hot rings. The lead ring advances on every rising input edge. The lag ring is loaded on every falling input edge. The output is bit 0 of the lead ring ORed with bit 0 of the lag ring. Each tap alone is high for one input period out of three. Because the lag tap trails the lead tap by half an input period, the OR of the two spans three half-periods. The halves of the output are equal only when the input clock itself has a 50% duty cycle.

Both rings repair themselves. A lead ring that holds anything other than exactly one set bit is reloaded with the start pattern on its next rising edge. The lag ring never rotates on its own. It copies the lead ring at each falling edge, or takes the start pattern if the lead ring is invalid at that moment. As a result, the two rings cannot drift apart for longer than half an input period. Reset is synchronous to each ring's own edge and forces the output low at once.

Top module: `tri_div_clk`

## Requirements
- R1: While rst_i is high, clk_o is 0 with no delay. Each ring loads 3'b001 (bit 0 set) at its own active edge while rst_i is high.
- R2: After rst_i falls, clk_o is 1 up to the first falling edge that follows the first rising edge after the release. After that falling edge, clk_o is 0.
- R3: Number the half-periods after the input edges from h = 0 at the first rising edge after the release. clk_o is 1 exactly when (h + 2) mod 6 is 0, 1 or 2. The lead ring steps 001 -> 010 -> 100 -> 001 (left rotate), so the output period is three input periods.
- R4: In steady operation, every high phase of clk_o lasts exactly three input half-periods. It starts at a rising input edge and ends at a falling input edge.
- R5: In steady operation, every low phase of clk_o lasts exactly three input half-periods.
- R6: When the lead ring holds a state with zero or several bits set, it becomes 3'b001 at the next rising edge. From that edge clk_o is 1 and follows the R3 pattern with h = 4.
- R7: When the lead ring is not one-hot at a falling edge, the lag ring loads 3'b001 at that edge, so clk_o is 1 after it.
- R8: At each falling edge with rst_i low, the lag ring loads the lead ring's value, so its tap trails the lead tap by exactly half an input period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; rising edges advance the lead ring, falling edges load the lag ring |
| rst_i | input | 1 | Active-high reset, sampled on both edges; gates clk_o low at once |
| clk_o | output | 1 | Divided clock, one third of the input frequency |

## Verification
Every ring update lands on the input edge that causes it, and clk_o follows the rings through gates only. The expected output for each half-period is therefore known as soon as that edge has passed. The bench samples clk_o a quarter of an input period after every edge, with a model index that steps once per edge. A reset assertion is checked one time unit after rst_i rises, since the gating takes no edge. After each forced ring corruption, the model jumps straight to the repaired phase. Duty-cycle checks resume only after two clean output transitions have been seen.

// File: rtl/tri_div_pkg.sv
package tri_div_pkg;

   localparam int DIV_RING_W = 3;

   localparam logic [DIV_RING_W-1:0] RING_START = DIV_RING_W'(1);

   function automatic logic ring_is_onehot(input logic [DIV_RING_W-1:0] v);
      int ones;
      ones = 0;
      for (int i = 0; i < DIV_RING_W; i++) begin
         ones += int'(v[i]);
      end
      return (ones == 1);
   endfunction

endpackage

// File: rtl/tri_div_lead_ring.sv
module tri_div_lead_ring #(
   parameter int RING_W = tri_div_pkg::DIV_RING_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   output logic [RING_W-1:0] ring_q
);
   import tri_div_pkg::*;

   if (RING_W != DIV_RING_W) begin : g_bad_width
      $error("tri_div_lead_ring: RING_W must equal %0d", DIV_RING_W);
   end

   logic [RING_W-1:0] rot_next;
   logic              state_ok;

   for (genvar b = 0; b < RING_W; b++) begin : g_rot
      assign rot_next[b] = ring_q[(b + RING_W - 1) % RING_W];
   end

   assign state_ok = ring_is_onehot(ring_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ring_q <= RING_START;
      end else if (!state_ok) begin
         ring_q <= RING_START;
      end else begin
         ring_q <= rot_next;
      end
   end

   AST_LEAD_ROTATE: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $onehot($past(ring_q)) && $onehot(ring_q))
         |-> (ring_q == {$past(ring_q[RING_W-2:0]), $past(ring_q[RING_W-1])})); // R3

   AST_LEAD_RECOVER: assert property (@(posedge clk_i) disable iff (rst_i)
      !$onehot(ring_q) |=> (ring_q == RING_START)); // R6

endmodule

// File: rtl/tri_div_lag_ring.sv
module tri_div_lag_ring #(
   parameter int RING_W = tri_div_pkg::DIV_RING_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [RING_W-1:0] lead_i,
   output logic [RING_W-1:0] ring_q
);
   import tri_div_pkg::*;

   if (RING_W != DIV_RING_W) begin : g_bad_width
      $error("tri_div_lag_ring: RING_W must equal %0d", DIV_RING_W);
   end

   logic lead_ok;

   assign lead_ok = ring_is_onehot(lead_i);

   always_ff @(negedge clk_i) begin
      if (rst_i) begin
         ring_q <= RING_START;
      end else if (!lead_ok) begin
         ring_q <= RING_START;
      end else begin
         ring_q <= lead_i;
      end
   end

   AST_LAG_FOLLOW: assert property (@(negedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $onehot($past(lead_i))) |-> (ring_q == $past(lead_i))); // R8

   AST_LAG_RECOVER: assert property (@(negedge clk_i) disable iff (rst_i)
      !$onehot(lead_i) |=> (ring_q == RING_START)); // R7

endmodule

// File: rtl/tri_div_merge.sv
module tri_div_merge #(
   parameter int RING_W = tri_div_pkg::DIV_RING_W,
   parameter int TAP    = 0
) (
   input  logic              rst_i,
   input  logic [RING_W-1:0] lead_i,
   input  logic [RING_W-1:0] lag_i,
   output logic              clk_o
);
   if (TAP < 0 || TAP >= RING_W) begin : g_bad_tap
      $error("tri_div_merge: TAP %0d outside ring of %0d bits", TAP, RING_W);
   end

   logic joined;

   assign joined = lead_i[TAP] | lag_i[TAP];
   assign clk_o  = joined & ~rst_i;

endmodule

// File: rtl/tri_div_clk.sv
module tri_div_clk #(
   parameter int RING_W = tri_div_pkg::DIV_RING_W,
   parameter int TAP    = 0
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic clk_o
);
   if (RING_W != tri_div_pkg::DIV_RING_W) begin : g_bad_width
      $error("tri_div_clk: only a three-stage ring is supported");
   end

   logic [RING_W-1:0] lead_q;
   logic [RING_W-1:0] lag_q;

   tri_div_lead_ring #(.RING_W(RING_W)) u_lead (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ring_q(lead_q)
   );

   tri_div_lag_ring #(.RING_W(RING_W)) u_lag (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .lead_i(lead_q),
      .ring_q(lag_q)
   );

   tri_div_merge #(.RING_W(RING_W), .TAP(TAP)) u_merge (
      .rst_i (rst_i),
      .lead_i(lead_q),
      .lag_i (lag_q),
      .clk_o (clk_o)
   );

endmodule

// File: tb/tri_div_clk_tb.sv
module tri_div_clk_tb;
   localparam int CLK_PERIOD = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_o;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 0;

   int  h       = 0;
   bit  pending = 0;
   bit  lead_fix = 0;
   bit  lag_fix  = 0;
   bit  last_pos = 0;
   int  trans   = 0;
   int  run     = 0;
   logic prev   = 1'b0;

   tri_div_clk u_dut (
      .clk_i(clk),
      .rst_i(rst),
      .clk_o(clk_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic phase_out(input int idx);
      return (((idx + 2) % 6) < 3);
   endfunction

   function automatic logic [2:0] bad_state(input int k);
      case (k % 5)
         0: return 3'b000;
         1: return 3'b011;
         2: return 3'b101;
         3: return 3'b110;
         default: return 3'b111;
      endcase
   endfunction

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: clk_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_run(input int act, input string req);
      checks++;
      if (act != 3) begin
         errors++;
         $display("FAIL %s: phase length %0d expected 3 at %0t", req, act, $time);
      end
   endtask

   task automatic half_step();
      logic  exp;
      string tag;
      @(clk);
      #(CLK_PERIOD/4);
      last_pos = clk;
      if (rst) begin
         exp = 1'b0; tag = "R1"; trans = 0;
      end else if (pending) begin
         if (last_pos) begin
            pending = 0; h = 0;
         end
         exp = 1'b1; tag = "R2"; trans = 0;
      end else if (last_pos) begin
         if (lead_fix) begin
            lead_fix = 0; h = 4; tag = "R6";
         end else begin
            h = (h + 1) % 6; tag = "R3";
         end
         exp = phase_out(h);
      end else begin
         if (lag_fix) begin
            lag_fix = 0; exp = 1'b1; tag = "R7";
         end else begin
            h = (h + 1) % 6; exp = phase_out(h); tag = (h == 1) ? "R2" : "R8";
         end
      end
      check(clk_o, exp, tag);
      if (clk_o !== prev) begin
         if (trans >= 2) check_run(run, prev ? "R4" : "R5");
         trans++;
         run = 1;
      end else begin
         run++;
      end
      prev = clk_o;
   endtask

   task automatic pulse_reset(input int half_len);
      rst = 1'b1;
      #1;
      check(clk_o, 1'b0, "R1");
      repeat (half_len) half_step();
      rst = 1'b0;
      pending = 1;
      lead_fix = 0;
      lag_fix = 0;
   endtask

   task automatic corrupt_lead(input logic [2:0] val, input bit after_pos);
      while (last_pos != after_pos) half_step();
      force u_dut.u_lead.ring_q = val;
      #1;
      release u_dut.u_lead.ring_q;
      lead_fix = 1;
      if (after_pos) lag_fix = 1;
      trans = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7391));
      // R1: reset state from time zero
      repeat (6) half_step();
      rst = 1'b0;
      pending = 1;
      repeat (30) half_step();

      // directed corner cases: empty ring and full ring, both phases
      corrupt_lead(3'b000, 1'b0);
      repeat (14) half_step();
      corrupt_lead(3'b111, 1'b1);
      repeat (14) half_step();
      corrupt_lead(3'b110, 1'b1);
      repeat (14) half_step();
      pulse_reset(4);
      repeat (20) half_step();

      for (int it = 0; it < 60; it++) begin
         int sel;
         sel = $urandom_range(0, 3);
         case (sel)
            0: repeat ($urandom_range(6, 30)) half_step();
            1: corrupt_lead(bad_state($urandom_range(0, 4)), 1'b0);
            2: corrupt_lead(bad_state($urandom_range(0, 4)), 1'b1);
            default: pulse_reset(2 * $urandom_range(2, 5) + $urandom_range(0, 1));
         endcase
         repeat (16) half_step();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule